// File: doc/BRIEF.md
# Configurable Fine-Grained Logic Cell

One programmable cell of a fine-grained logic array, held in a fixed configuration by a static 13-bit word. The cell takes two signals, A and B, from its surroundings. Each one is chosen on its own from the four adjacent cells or tied to logic one. The cell runs them through an inner function and presents the two results on all four of its sides.

The inner function has four settings: pass-through, swap, combinational half adder, and half adder with the sum and carry held in a flip-flop. An outer edge stage attaches the cell to one of four local bus segments. Buses 0 and 1 run horizontally and buses 2 and 3 run vertically. The edge stage has six behaviours:
- Two of them gate the inner inputs with the selected bus.
- Two of them drive the inner A result onto the selected bus, one always and one under control of the B result.
- Two of them turn a signal from a horizontal segment onto a vertical segment, or back.

Any inner setting can be combined with any edge behaviour. In the turn behaviours the inner function does not read the bus.

Each bus output is modelled as a value plus a drive enable, so the array around the cell can check that only one source drives each segment.

Top module: `logic_cell`

## Requirements
- R1: The A source select (cfg bits 7:5) and the B source select (cfg bits 4:2) each pick a neighbour bit. Values 0..3 select index 0..3 of the neighbour inputs (N, E, S, W). Values 4..7 select a constant one.
- R2: With inner setting 0 (cfg bits 12:11), result A equals inner input A and result B equals inner input B, with no clock delay.
- R3: With inner setting 1, result A equals inner input B and result B equals inner input A, with no clock delay.
- R4: With inner setting 2, result A is A XOR B and result B is A AND B, with no clock delay.
- R5: With inner setting 3, the results are the half-adder sum and carry of the inner inputs, captured at the previous rising clock edge. While rst_ni is low, both results are 0.
- R6: Result A is driven on all four bits of side_a_o, and result B on all four bits of side_b_o.
- R7: In read mode (cfg bits 10:8 = 3), and in the reserved codes 6 and 7, inner input A is the selected source AND the local bus L. L is bus index cfg bits 1:0. B is not gated, and no bus enable is raised.
- R8: In mux mode (code 2), inner A is source A AND L and inner B is source B AND NOT L. No bus enable is raised. Combined with inner setting 2, result A equals L ? A : B.
- R9: In write mode (code 5), only bus L is enabled, and it is driven with result A.
- R10: In gated-write mode (code 4), bus L is enabled exactly when result B is 1, and it is then driven with result A. No other bus is enabled.
- R11: In turn-forward mode (code 0), bus L XOR 2 is enabled and driven with the value of bus L. In turn-reverse mode (code 1), bus L is enabled and driven with the value of bus L XOR 2. In both turn modes the inner inputs are the ungated sources.
- R12: At most one bus enable is high at any time. A bus whose enable is low has a drive value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the inner flip-flop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 13 | Static configuration: {inner setting[1:0], edge mode[2:0], A source[2:0], B source[2:0], bus select[1:0]} |
| nbr_a_i | input | 4 | Candidate A inputs from the N, E, S, W neighbours (index 0..3) |
| nbr_b_i | input | 4 | Candidate B inputs from the N, E, S, W neighbours (index 0..3) |
| lbus_i | input | 4 | Present values of the four local bus segments |
| side_a_o | output | 4 | Result A, copied to the N, E, S, W sides |
| side_b_o | output | 4 | Result B, copied to the N, E, S, W sides |
| lbus_drv_o | output | 4 | Drive value for each bus segment |
| lbus_en_o | output | 4 | Drive enable for each bus segment |

## Verification
The bench builds the cell with the default values: four neighbours and four bus segments, two horizontal and two vertical. With these values every source select code and every bus index can be swept exhaustively, including the constant-one codes and both corner-turn directions between the horizontal and vertical pairs. Every mode is crossed with every value of the bus bit, so the gating edge cases are covered, as is the half-adder mux built from mux mode and inner setting 2. The registered inner setting is checked both during reset and when its inputs change from cycle to cycle.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int NUM_NBR  = 4;
  localparam int NUM_BUS  = 4;
  localparam int NUM_SIDE = 4;
  localparam int SRC_W    = 3;
  localparam int BSEL_W   = $clog2(NUM_BUS);

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_SWAP = 2'd1,
    FN_HADD = 2'd2,
    FN_HREG = 2'd3
  } core_fn_e;

  typedef enum logic [2:0] {
    MD_TURN_FWD = 3'd0,
    MD_TURN_REV = 3'd1,
    MD_MUX      = 3'd2,
    MD_READ     = 3'd3,
    MD_GWRITE   = 3'd4,
    MD_WRITE    = 3'd5,
    MD_RSV6     = 3'd6,
    MD_RSV7     = 3'd7
  } edge_mode_e;

  typedef struct packed {
    core_fn_e          fn;
    edge_mode_e        mode;
    logic [SRC_W-1:0]  src_a;
    logic [SRC_W-1:0]  src_b;
    logic [BSEL_W-1:0] bus_sel;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lcell_src_mux.sv
module lcell_src_mux #(
  parameter int NSRC  = lcell_pkg::NUM_NBR,
  parameter int SEL_W = lcell_pkg::SRC_W
) (
  input  logic [NSRC-1:0]  nbr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sig_o
);
  localparam int IDX_W = $clog2(NSRC);

  // codes past the neighbour range tie the input high
  always_comb begin
    if (sel_i < SEL_W'(NSRC)) sig_o = nbr_i[sel_i[IDX_W-1:0]];
    else                      sig_o = 1'b1;
  end
endmodule

// File: rtl/lcell_edge_in.sv
module lcell_edge_in
  import lcell_pkg::*;
(
  input  edge_mode_e mode_i,
  input  logic       a_raw_i,
  input  logic       b_raw_i,
  input  logic       lbus_i,
  output logic       a_o,
  output logic       b_o
);
  always_comb begin
    a_o = a_raw_i;
    b_o = b_raw_i;
    unique case (mode_i)
      MD_MUX: begin
        a_o = a_raw_i & lbus_i;
        b_o = b_raw_i & ~lbus_i;
      end
      MD_READ, MD_RSV6, MD_RSV7: a_o = a_raw_i & lbus_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/lcell_core.sv
module lcell_core
  import lcell_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  core_fn_e fn_i,
  input  logic     a_i,
  input  logic     b_i,
  output logic     a_o,
  output logic     b_o
);
  logic sum_d, cry_d, sum_q, cry_q;

  assign sum_d = a_i ^ b_i;
  assign cry_d = a_i & b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= 1'b0;
      cry_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      cry_q <= cry_d;
    end
  end

  always_comb begin
    unique case (fn_i)
      FN_PASS: begin a_o = a_i;   b_o = b_i;   end
      FN_SWAP: begin a_o = b_i;   b_o = a_i;   end
      FN_HADD: begin a_o = sum_d; b_o = cry_d; end
      default: begin a_o = sum_q; b_o = cry_q; end
    endcase
  end
endmodule

// File: rtl/lcell_edge_out.sv
module lcell_edge_out
  import lcell_pkg::*;
#(
  parameter int NBUS = lcell_pkg::NUM_BUS
) (
  input  edge_mode_e              mode_i,
  input  logic [$clog2(NBUS)-1:0] bus_sel_i,
  input  logic [NBUS-1:0]         lbus_i,
  input  logic                    res_a_i,
  input  logic                    res_b_i,
  output logic [NBUS-1:0]         drv_o,
  output logic [NBUS-1:0]         en_o
);
  localparam int SW = $clog2(NBUS);
  // upper half of the segments runs orthogonally to the lower half
  localparam logic [SW-1:0] TURN_FLIP = SW'(NBUS / 2);

  logic [SW-1:0] partner;
  assign partner = bus_sel_i ^ TURN_FLIP;

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    logic hit_sel, hit_par, en, val;
    assign hit_sel = (bus_sel_i == SW'(g));
    assign hit_par = (partner == SW'(g));

    always_comb begin
      en  = 1'b0;
      val = 1'b0;
      unique case (mode_i)
        MD_TURN_FWD: begin en = hit_par;            val = lbus_i[bus_sel_i]; end
        MD_TURN_REV: begin en = hit_sel;            val = lbus_i[partner];   end
        MD_GWRITE:   begin en = hit_sel & res_b_i;  val = res_a_i;           end
        MD_WRITE:    begin en = hit_sel;            val = res_a_i;           end
        default: ;
      endcase
    end

    assign en_o[g]  = en;
    assign drv_o[g] = en & val;
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
#(
  parameter int NNBR  = lcell_pkg::NUM_NBR,
  parameter int NBUS  = lcell_pkg::NUM_BUS,
  parameter int NSIDE = lcell_pkg::NUM_SIDE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [NNBR-1:0]  nbr_a_i,
  input  logic [NNBR-1:0]  nbr_b_i,
  input  logic [NBUS-1:0]  lbus_i,
  output logic [NSIDE-1:0] side_a_o,
  output logic [NSIDE-1:0] side_b_o,
  output logic [NBUS-1:0]  lbus_drv_o,
  output logic [NBUS-1:0]  lbus_en_o
);
  cell_cfg_t cfg;
  logic a_raw, b_raw, l_bit, a_in, b_in, res_a, res_b;

  assign cfg   = cell_cfg_t'(cfg_i);
  assign l_bit = lbus_i[cfg.bus_sel];

  lcell_src_mux #(.NSRC(NNBR), .SEL_W(SRC_W)) u_src_a (
    .nbr_i(nbr_a_i), .sel_i(cfg.src_a), .sig_o(a_raw)
  );
  lcell_src_mux #(.NSRC(NNBR), .SEL_W(SRC_W)) u_src_b (
    .nbr_i(nbr_b_i), .sel_i(cfg.src_b), .sig_o(b_raw)
  );

  lcell_edge_in u_edge_in (
    .mode_i(cfg.mode), .a_raw_i(a_raw), .b_raw_i(b_raw),
    .lbus_i(l_bit), .a_o(a_in), .b_o(b_in)
  );

  lcell_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .fn_i(cfg.fn),
    .a_i(a_in), .b_i(b_in), .a_o(res_a), .b_o(res_b)
  );

  lcell_edge_out #(.NBUS(NBUS)) u_edge_out (
    .mode_i(cfg.mode), .bus_sel_i(cfg.bus_sel), .lbus_i(lbus_i),
    .res_a_i(res_a), .res_b_i(res_b), .drv_o(lbus_drv_o), .en_o(lbus_en_o)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    assign side_a_o[s] = res_a;
    assign side_b_o[s] = res_b;
  end
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk
  import lcell_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CFG_W-1:0]    cfg_i,
  input logic [NUM_BUS-1:0]  lbus_i,
  input logic [NUM_SIDE-1:0] side_a_o,
  input logic [NUM_SIDE-1:0] side_b_o,
  input logic [NUM_BUS-1:0]  lbus_drv_o,
  input logic [NUM_BUS-1:0]  lbus_en_o
);
  cell_cfg_t c;
  logic [BSEL_W-1:0] par;
  assign c   = cell_cfg_t'(cfg_i);
  assign par = c.bus_sel ^ BSEL_W'(NUM_BUS / 2);

  // R12
  single_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lbus_en_o) && ((lbus_drv_o & ~lbus_en_o) == '0));

  // R6
  side_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_a_o == {NUM_SIDE{side_a_o[0]}} && side_b_o == {NUM_SIDE{side_b_o[0]}});

  // R7
  read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c.mode == MD_READ || c.mode == MD_RSV6 || c.mode == MD_RSV7 || c.mode == MD_MUX)
      |-> lbus_en_o == '0);

  // R9
  write_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c.mode == MD_WRITE |-> lbus_en_o == (NUM_BUS'(1) << c.bus_sel)
                           && lbus_drv_o[c.bus_sel] == side_a_o[0]);

  // R10
  gated_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c.mode == MD_GWRITE |-> lbus_en_o[c.bus_sel] == side_b_o[0]);

  // R11
  turn_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c.mode == MD_TURN_FWD |-> lbus_en_o[par] && lbus_drv_o[par] == lbus_i[c.bus_sel]);

  // R4
  hadd_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c.fn == FN_HADD && c.mode == MD_WRITE && c.src_a >= 3'd4 && c.src_b >= 3'd4)
      |-> !side_a_o[0] && side_b_o[0]);

  // R5
  hreg_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c.fn == FN_HREG && $past(rst_ni) && $past(c.fn == FN_HREG) && $past(c.mode == MD_WRITE)
      && $past(c.src_a >= 3'd4) && $past(c.src_b >= 3'd4))
      |-> !side_a_o[0] && side_b_o[0]);
endmodule

bind logic_cell logic_cell_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .lbus_i(lbus_i),
  .side_a_o(side_a_o), .side_b_o(side_b_o),
  .lbus_drv_o(lbus_drv_o), .lbus_en_o(lbus_en_o)
);

// File: tb/logic_cell_tb.sv
`timescale 1ns/1ps
module logic_cell_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] cfg_i = '0;
  logic [3:0]  nbr_a_i = '0, nbr_b_i = '0, lbus_i = '0;
  logic [3:0]  side_a_o, side_b_o, lbus_drv_o, lbus_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  sb_item_t cur;

  always #2.5 clk_i = ~clk_i;

  logic_cell u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i),
    .nbr_a_i(nbr_a_i), .nbr_b_i(nbr_b_i), .lbus_i(lbus_i),
    .side_a_o(side_a_o), .side_b_o(side_b_o),
    .lbus_drv_o(lbus_drv_o), .lbus_en_o(lbus_en_o)
  );

  function automatic logic [12:0] mk(int st, int md, int sa, int sb, int ls);
    return {st[1:0], md[2:0], sa[2:0], sb[2:0], ls[1:0]};
  endfunction

  // reference from the requirements
  function automatic logic [15:0] model(logic [12:0] c, logic [3:0] na, logic [3:0] nb, logic [3:0] lb);
    logic [1:0] st, ls, lp;
    logic [2:0] md, sa, sb;
    logic a, b, l, oa, ob;
    logic [3:0] en, drv;
    st = c[12:11]; md = c[10:8]; sa = c[7:5]; sb = c[4:2]; ls = c[1:0];
    lp = ls ^ 2'd2;
    a = (sa < 3'd4) ? na[sa[1:0]] : 1'b1;
    b = (sb < 3'd4) ? nb[sb[1:0]] : 1'b1;
    l = lb[ls];
    if (md == 3'd2) begin a = a & l; b = b & ~l; end
    else if (md == 3'd3 || md >= 3'd6) a = a & l;
    case (st)
      2'd0: begin oa = a; ob = b; end
      2'd1: begin oa = b; ob = a; end
      default: begin oa = a ^ b; ob = a & b; end
    endcase
    en = '0; drv = '0;
    case (md)
      3'd0: begin en[lp] = 1'b1; drv[lp] = lb[ls]; end
      3'd1: begin en[ls] = 1'b1; drv[ls] = lb[lp]; end
      3'd4: begin en[ls] = ob;   drv[ls] = ob & oa; end
      3'd5: begin en[ls] = 1'b1; drv[ls] = oa; end
      default: ;
    endcase
    return {{4{oa}}, {4{ob}}, drv, en};
  endfunction

  task automatic drive(logic [12:0] c, logic [3:0] na, logic [3:0] nb, logic [3:0] lb, string tag);
    sb_item_t it;
    @(negedge clk_i);
    cfg_i = c; nbr_a_i = na; nbr_b_i = nb; lbus_i = lb;
    it.exp = model(c, na, nb, lb);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: inputs set at a negedge are judged just after the following posedge
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      n_chk++;
      if ({side_a_o, side_b_o, lbus_drv_o, lbus_en_o} !== cur.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", cur.tag,
                 {side_a_o, side_b_o, lbus_drv_o, lbus_en_o}, cur.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R5 reset: registered half adder cleared, write mode drives 0
    cfg_i = mk(3, 5, 4, 0, 0); nbr_b_i = 4'b0000;
    repeat (3) @(posedge clk_i);
    #1;
    n_chk++;
    if ({side_a_o, side_b_o, lbus_drv_o, lbus_en_o} !== 16'h0001) begin
      n_fail++;
      $display("FAIL R5 reset: got %h expected %h", {side_a_o, side_b_o, lbus_drv_o, lbus_en_o}, 16'h0001);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 source selection over all codes
    for (int s = 0; s < 8; s++) drive(mk(0, 5, s, 4, 0), 4'b0101, 4'b0000, 4'h0, "R1");
    for (int s = 0; s < 8; s++) drive(mk(0, 5, 4, s, 1), 4'b0000, 4'b0110, 4'h0, "R1");
    // R2 / R3 straight and crossed
    for (int p = 0; p < 16; p++) drive(mk(0, 5, p % 4, 3 - p % 4, 2), p[3:0], ~p[3:0], 4'h0, "R2");
    for (int p = 0; p < 16; p++) drive(mk(1, 5, p % 4, 3 - p % 4, 3), p[3:0], ~p[3:0], 4'h0, "R3");
    // R4 combinational half adder
    for (int p = 0; p < 4; p++) drive(mk(2, 5, 0, 0, 0), {3'b000, p[0]}, {3'b000, p[1]}, 4'h0, "R4");
    // R5 registered half adder, inputs changing every cycle
    for (int p = 0; p < 8; p++) drive(mk(3, 5, 1, 2, 0), {2'b00, p[0], 1'b0}, {1'b0, p[1], 2'b00}, 4'h0, "R5");
    // R6 side replication
    drive(mk(1, 3, 0, 3, 0), 4'b0000, 4'b1000, 4'h1, "R6");
    drive(mk(0, 3, 0, 3, 0), 4'b0001, 4'b0000, 4'h1, "R6");
    // R7 read and reserved codes
    for (int m = 3; m < 8; m++) begin
      if (m == 4 || m == 5) continue;
      for (int l = 0; l < 2; l++) drive(mk(0, m, 4, 4, 2), 4'h0, 4'h0, l[0] ? 4'b0100 : 4'b1011, "R7");
    end
    // R8 mux from mux mode plus half adder
    for (int p = 0; p < 8; p++)
      drive(mk(2, 2, 0, 0, 1), {3'b000, p[0]}, {3'b000, p[1]}, {2'b00, p[2], 1'b0}, "R8");
    // R9 write on every bus
    for (int ls = 0; ls < 4; ls++) drive(mk(0, 5, 0, 0, ls), 4'b0001, 4'b0000, 4'h0, "R9");
    for (int ls = 0; ls < 4; ls++) drive(mk(1, 5, 0, 0, ls), 4'b0000, 4'b0001, 4'hF, "R9");
    // R10 gated write
    for (int ls = 0; ls < 4; ls++)
      for (int b = 0; b < 2; b++) drive(mk(0, 4, 4, 0, ls), 4'h0, {3'b000, b[0]}, 4'h0, "R10");
    // R11 corner turns both ways
    for (int m = 0; m < 2; m++)
      for (int ls = 0; ls < 4; ls++)
        for (int v = 0; v < 2; v++)
          drive(mk(0, m, 0, 1, ls), 4'b0001, 4'b0010, v[0] ? 4'b0101 : 4'b1010, "R11");
    drive(mk(2, 0, 4, 4, 0), 4'h0, 4'h0, 4'h0, "R11");
    // R12 single driver across every mode
    for (int m = 0; m < 8; m++) drive(mk(3, m, 4, 0, 3), 4'h0, 4'h0, 4'hF, "R12");

    while (sb_q.size() > 0) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule